// File: doc/BRIEF.md
# CAN Controller Transmit/Receive Status and Transmit-Buffer Lock

This block keeps the host-visible status flags of a CAN controller that describe transmission progress, transmit-buffer ownership and receive-FIFO occupancy, and it decides whether a host write into the transmit buffer RAM may proceed. It sits between the host command decoder, the protocol engine and the receive FIFO. It holds no frame storage and does no bit-level framing.

A transmit or self-reception command hands the transmit buffer to the protocol engine. The buffer then reads locked, and the transmission-done flag drops. The flag stays low until the engine reports a successful send. The buffer is handed back when that send succeeds or when the engine drops the pending frame. While the buffer is locked, host writes are discarded without any indication. The receive-buffer flag follows the FIFO message count, which the FIFO lowers by one for every honoured release command. The bus is reported idle only when neither the receive-active nor the transmit-active flag is set.

Top module: `can_stat_lock`

## Requirements
- R1: After reset, stat_tx_done is 1, stat_tbuf_free is 1, stat_rbuf_full is 0, stat_rx_busy and stat_tx_busy are 0, and stat_bus_idle is 1.
- R2: stat_rx_busy and stat_tx_busy equal eng_rx_active and eng_tx_active from the previous clock edge, and stat_bus_idle is 1 exactly when both of those sampled flags are 0.
- R3: A cycle with cmd_tx_req or cmd_self_req high makes stat_tx_done 0 after the next clock edge.
- R4: stat_tx_done becomes 1 only after an edge on which eng_tx_ok was high while the buffer was locked. An engine abort leaves it at 0.
- R5: A cycle with cmd_tx_req or cmd_self_req high makes stat_tbuf_free 0 after the next edge. While the buffer is locked, an eng_tx_ok or eng_tx_abort pulse makes it 1 after the next edge.
- R6: tbuf_wr_accept equals host_tbuf_wr in the same cycle when stat_tbuf_free is 1, and is 0 when it is 0. A dropped write changes no status output.
- R7: stat_rbuf_full equals (fifo_msg_cnt != 0) as sampled at the previous edge, so it clears only once every message has been released.
- R8: fifo_release equals cmd_rel_rx in the same cycle when fifo_msg_cnt is nonzero. A release command with an empty FIFO gives no pulse.
- R9: When a request and eng_tx_ok arrive in the same cycle, the request wins: after the edge, stat_tx_done is 0 and stat_tbuf_free is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_tx_req | input | 1 | Host transmit command strobe |
| cmd_self_req | input | 1 | Host self-reception command strobe |
| cmd_rel_rx | input | 1 | Host release-receive-buffer command strobe |
| eng_tx_ok | input | 1 | Protocol engine: frame sent successfully (pulse) |
| eng_tx_abort | input | 1 | Protocol engine: pending frame dropped (pulse) |
| eng_rx_active | input | 1 | Protocol engine is receiving |
| eng_tx_active | input | 1 | Protocol engine is transmitting |
| fifo_msg_cnt | input | CNT_W | Messages held in the receive FIFO |
| host_tbuf_wr | input | 1 | Host write enable toward the transmit buffer |
| tbuf_wr_accept | output | 1 | Write enable passed to the transmit-buffer RAM |
| fifo_release | output | 1 | Pop strobe to the receive FIFO |
| stat_tx_done | output | 1 | Last transmission completed |
| stat_tbuf_free | output | 1 | Transmit buffer released to the host (0 = locked) |
| stat_rbuf_full | output | 1 | At least one message waits in the FIFO |
| stat_rx_busy | output | 1 | Receive in progress |
| stat_tx_busy | output | 1 | Transmit in progress |
| stat_bus_idle | output | 1 | Neither receive nor transmit in progress |

## Verification
The two gating outputs, tbuf_wr_accept and fifo_release, respond in the same cycle, so they are checked one time step after the inputs change at the falling edge. Every status flag passes through one register and is due after the next rising edge. The bench drives inputs at each falling edge. It compares the gating outputs shortly after driving them, and it compares the status flags at the following falling edge against a model that is stepped once per cycle with the same inputs. Directed sequences cover a request arriving together with a success pulse, an abort, release commands on an empty FIFO, and writes to a locked buffer.

// File: rtl/cs_pkg.sv
package cs_pkg;
    typedef struct packed {
        logic done;
        logic free;
    } tx_state_t;

    typedef struct packed {
        logic rx;
        logic tx;
        logic idle;
    } bus_state_t;
endpackage

// File: rtl/cs_tx_track.sv
module cs_tx_track
    import cs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tx_req,
    input  logic self_req,
    input  logic eng_ok,
    input  logic eng_abort,
    input  logic wr_en,
    output logic done,
    output logic free,
    output logic wr_accept
);
    tx_state_t st_d, st_q;
    logic      req;

    assign req = tx_req | self_req;

    always_comb begin
        st_d = st_q;
        if (req) begin
            st_d.done = 1'b0;
            st_d.free = 1'b0;
        end else if (!st_q.free) begin
            if (eng_ok) begin
                st_d.done = 1'b1;
            end
            if (eng_ok || eng_abort) begin
                st_d.free = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{done: 1'b1, free: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign done      = st_q.done;
    assign free      = st_q.free;
    assign wr_accept = wr_en & st_q.free;

    AST_REQ_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req || self_req) |=> !done); // R3
    AST_DONE_NEEDS_OK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(eng_ok) && !$past(free))); // R4
    AST_REQ_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req || self_req) |=> !free); // R5
    AST_REQ_BEATS_OK: assert property (@(posedge clk) disable iff (!rst_n)
        ((tx_req || self_req) && eng_ok) |=> (!done && !free)); // R9
endmodule

// File: rtl/cs_rx_track.sv
module cs_rx_track #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] msg_cnt,
    input  logic             rel_cmd,
    output logic             rbuf_full,
    output logic             pop
);
    logic full_d, full_q;
    logic nonempty;

    assign nonempty = (msg_cnt != '0);

    always_comb begin
        full_d = nonempty;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full_q <= 1'b0;
        end else begin
            full_q <= full_d;
        end
    end

    assign rbuf_full = full_q;
    assign pop       = rel_cmd & nonempty;

    AST_RBUF_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_cnt != '0) |=> rbuf_full); // R7
    AST_RBUF_CLEARS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rbuf_full) |-> ($past(msg_cnt) == '0)); // R7
    AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_cnt == '0) |-> !pop); // R8
endmodule

// File: rtl/cs_bus_track.sv
module cs_bus_track
    import cs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rx_active,
    input  logic tx_active,
    output logic rx_busy,
    output logic tx_busy,
    output logic bus_idle
);
    bus_state_t st_d, st_q;

    always_comb begin
        st_d.rx   = rx_active;
        st_d.tx   = tx_active;
        st_d.idle = ~(rx_active | tx_active);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{rx: 1'b0, tx: 1'b0, idle: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign rx_busy  = st_q.rx;
    assign tx_busy  = st_q.tx;
    assign bus_idle = st_q.idle;

    AST_IDLE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_idle |-> (!rx_busy && !tx_busy)); // R2
    AST_BUSY_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_active || tx_active) |=> !bus_idle); // R2
endmodule

// File: rtl/can_stat_lock.sv
module can_stat_lock #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_tx_req,
    input  logic             cmd_self_req,
    input  logic             cmd_rel_rx,
    input  logic             eng_tx_ok,
    input  logic             eng_tx_abort,
    input  logic             eng_rx_active,
    input  logic             eng_tx_active,
    input  logic [CNT_W-1:0] fifo_msg_cnt,
    input  logic             host_tbuf_wr,
    output logic             tbuf_wr_accept,
    output logic             fifo_release,
    output logic             stat_tx_done,
    output logic             stat_tbuf_free,
    output logic             stat_rbuf_full,
    output logic             stat_rx_busy,
    output logic             stat_tx_busy,
    output logic             stat_bus_idle
);
    cs_tx_track u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_req    (cmd_tx_req),
        .self_req  (cmd_self_req),
        .eng_ok    (eng_tx_ok),
        .eng_abort (eng_tx_abort),
        .wr_en     (host_tbuf_wr),
        .done      (stat_tx_done),
        .free      (stat_tbuf_free),
        .wr_accept (tbuf_wr_accept)
    );

    cs_rx_track #(.CNT_W(CNT_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .msg_cnt   (fifo_msg_cnt),
        .rel_cmd   (cmd_rel_rx),
        .rbuf_full (stat_rbuf_full),
        .pop       (fifo_release)
    );

    cs_bus_track u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_active (eng_rx_active),
        .tx_active (eng_tx_active),
        .rx_busy   (stat_rx_busy),
        .tx_busy   (stat_tx_busy),
        .bus_idle  (stat_bus_idle)
    );

    AST_LOCKED_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_tx_req || cmd_self_req) |=> !tbuf_wr_accept); // R6
endmodule

// File: tb/test_can_stat_lock.sv
`timescale 1ns/1ps
module test_can_stat_lock;
    localparam int CNT_W = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_tx_req = 0, cmd_self_req = 0, cmd_rel_rx = 0;
    logic eng_tx_ok = 0, eng_tx_abort = 0, eng_rx_active = 0, eng_tx_active = 0;
    logic [CNT_W-1:0] fifo_msg_cnt = '0;
    logic host_tbuf_wr = 0;
    logic tbuf_wr_accept, fifo_release;
    logic stat_tx_done, stat_tbuf_free, stat_rbuf_full;
    logic stat_rx_busy, stat_tx_busy, stat_bus_idle;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic m_done, m_free, m_rbuf, m_rx, m_tx, m_idle;

    always #2.5 clk = ~clk;

    can_stat_lock #(.CNT_W(CNT_W)) i_can_stat_lock (.*);

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic exp_accept(input logic wr, input logic free);
        return wr & free;
    endfunction

    function automatic logic exp_pop(input logic rel, input logic [CNT_W-1:0] cnt);
        return rel & (cnt != '0);
    endfunction

    task automatic check_state();
        chk("R4 done", stat_tx_done, m_done);
        chk("R5 free", stat_tbuf_free, m_free);
        chk("R7 rbuf", stat_rbuf_full, m_rbuf);
        chk("R2 rx", stat_rx_busy, m_rx);
        chk("R2 tx", stat_tx_busy, m_tx);
        chk("R2 idle", stat_bus_idle, m_idle);
    endtask

    // one cycle: called just after a falling edge
    task automatic cyc(input logic tx, input logic sf, input logic ok, input logic ab,
                       input logic rel, input logic rxa, input logic txa,
                       input logic [CNT_W-1:0] cnt, input logic wr);
        logic req;
        cmd_tx_req = tx; cmd_self_req = sf; eng_tx_ok = ok; eng_tx_abort = ab;
        cmd_rel_rx = rel; eng_rx_active = rxa; eng_tx_active = txa;
        fifo_msg_cnt = cnt; host_tbuf_wr = wr;
        #1;
        chk("R6 accept", tbuf_wr_accept, exp_accept(wr, m_free));
        chk("R8 release", fifo_release, exp_pop(rel, cnt));
        req = tx | sf;
        if (req) begin
            m_done = 0; m_free = 0;
        end else if (!m_free) begin
            if (ok) m_done = 1;
            if (ok || ab) m_free = 1;
        end
        m_rbuf = (cnt != '0);
        m_rx = rxa; m_tx = txa; m_idle = ~(rxa | txa);
        @(negedge clk);
        check_state();
    endtask

    initial begin
        m_done = 1; m_free = 1; m_rbuf = 0; m_rx = 0; m_tx = 0; m_idle = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 done", stat_tx_done, 1'b1);
        chk("R1 free", stat_tbuf_free, 1'b1);
        chk("R1 rbuf", stat_rbuf_full, 1'b0);
        chk("R1 rx", stat_rx_busy, 1'b0);
        chk("R1 tx", stat_tx_busy, 1'b0);
        chk("R1 idle", stat_bus_idle, 1'b1);

        // R3/R5: request locks buffer and clears done
        cyc(1,0,0,0, 0,0,0, 0, 1);
        chk("R3 done cleared", stat_tx_done, 1'b0);
        // R6: write while locked is dropped
        cyc(0,0,0,0, 0,0,1, 0, 1);
        chk("R6 locked no accept", tbuf_wr_accept, 1'b0);
        // R4: success sets done and releases
        cyc(0,0,1,0, 0,0,0, 0, 0);
        chk("R4 done set", stat_tx_done, 1'b1);
        // R3 self-reception request, then abort
        cyc(0,1,0,0, 0,0,0, 0, 0);
        cyc(0,0,0,1, 0,0,0, 0, 0);
        chk("R4 abort keeps done low", stat_tx_done, 1'b0);
        chk("R5 abort frees", stat_tbuf_free, 1'b1);
        // R4: success pulse while free does not set done
        cyc(0,0,1,0, 0,0,0, 0, 0);
        chk("R4 ok while free ignored", stat_tx_done, 1'b0);
        // R9: request with simultaneous ok
        cyc(1,0,1,0, 0,0,0, 0, 0);
        chk("R9 done", stat_tx_done, 1'b0);
        chk("R9 free", stat_tbuf_free, 1'b0);
        cyc(0,0,1,0, 0,0,0, 0, 0);
        // R7/R8: FIFO drain, release on empty ignored
        cyc(0,0,0,0, 0,1,0, 2, 0);
        cyc(0,0,0,0, 1,1,1, 2, 0);
        cyc(0,0,0,0, 1,0,0, 1, 0);
        chk("R7 still full", stat_rbuf_full, 1'b1);
        cyc(0,0,0,0, 1,0,0, 0, 0);
        chk("R7 cleared", stat_rbuf_full, 1'b0);

        process::self().srandom(32'd1234);
        for (int i = 0; i < 3000; i++) begin
            logic [CNT_W-1:0] c;
            c = ($urandom_range(0, 2) == 0) ? '0 : CNT_W'($urandom_range(0, 5));
            cyc($urandom_range(0, 9) == 0, $urandom_range(0, 12) == 0,
                $urandom_range(0, 3) == 0, $urandom_range(0, 7) == 0,
                $urandom_range(0, 2) == 0, $urandom_range(0, 1) == 1,
                $urandom_range(0, 1) == 1, c, $urandom_range(0, 1) == 1);
        end
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule